// File: doc/BRIEF.md
# Sector-to-DMA Stream Adapter

The adapter sits between a storage unit that delivers data one whole sector at a time and a DMA channel that moves data to host memory. A packet command names a starting logical block and a total byte count. The DMA channel then posts one or more requests, each with a target address and a byte length. A request may be much shorter than a sector; 512-byte requests against 2048-byte sectors are typical. The adapter copies bytes from a local sector buffer onto a streaming memory-write port. It keeps its position inside the buffered sector from one request to the next, so a sector is fetched once even when several requests consume it.

Sectors arrive over a ready/valid fill port. When the adapter has no valid sector and packet bytes are still owed, it asks for the sector at its current block address. While the fill is under way the memory-write output stays idle. Consuming the last byte of a sector moves the block address forward by one and starts the next fill. A finished request is reported with a one-cycle end pulse. A finished packet is reported with a completion status, an interrupt-reason code and a level interrupt. A fill error closes the open request, aborts the packet and reports an error status.

Top module: `ssa_adapter`

## Requirements
- R1: After reset, status is 0x40, int_reason is 0, irq is low, cmd_ready and dreq_ready are high, and mw_valid and fill_ready are low.
- R2: A packet command is accepted when cmd_valid and cmd_ready are both high. It loads the block address from cmd_lba and the owed count from cmd_bytes (non-zero), clears the in-sector offset, drops any buffered sector, and clears irq and int_reason. Status is then 0x80 and cmd_ready stays low until the packet completes or faults.
- R3: Each memory-write beat carries the byte at the current offset of the sector at the current block address. mw_addr starts at dreq_addr and rises by one after each accepted beat of that request.
- R4: The in-sector offset is kept across requests. When the offset passes the last byte of a sector (SECT_BYTES, default 2048) it returns to 0, the block address rises by one and that sector is fetched next. There is no other refetch within a packet.
- R5: fill_ready is high exactly while a packet is active and no sector is buffered, with fill_lba equal to the current block address. A sector is complete after SECT_BYTES accepted fill beats. mw_valid stays low while no sector is buffered.
- R6: dma_end pulses high for one cycle, in the cycle after the beat that brings the request length to zero. dreq_ready is high again in that same cycle.
- R7: In the cycle after the beat that brings the packet count to zero, status is 0x50, int_reason is 3'b011 (bit 1 data toward host, bit 0 command phase complete), irq is high and cmd_ready is high. No further beats are issued.
- R8: If the packet ends before the request, the request stays open with its remaining length and address and no dma_end is given. It resumes once the next packet command supplies bytes.
- R9: A fill beat with fill_err set aborts the packet. If a request is open, dma_end pulses once in the next cycle. Status becomes 0x41, int_reason 3'b011 and irq high. Without an open request, no dma_end is given.
- R10: While mw_valid is high and mw_ready is low, mw_valid, mw_addr and mw_data hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Packet command offered |
| cmd_ready | output | 1 | No packet active; command can be taken |
| cmd_lba | input | LBA_W | Starting logical block |
| cmd_bytes | input | PKT_W | Total packet bytes, non-zero |
| dreq_valid | input | 1 | DMA request offered |
| dreq_ready | output | 1 | No request open; request can be taken |
| dreq_addr | input | ADDR_W | Request target address |
| dreq_len | input | LEN_W | Request byte length, non-zero |
| dma_end | output | 1 | One-cycle end-of-request pulse |
| fill_ready | output | 1 | Adapter wants sector bytes |
| fill_lba | output | LBA_W | Block being requested |
| fill_valid | input | 1 | Sector byte offered |
| fill_data | input | 8 | Sector byte |
| fill_err | input | 1 | Storage read error, qualified by fill_valid |
| mw_valid | output | 1 | Memory-write beat offered |
| mw_ready | input | 1 | Memory accepts beat |
| mw_addr | output | ADDR_W | Beat address |
| mw_data | output | 8 | Beat byte |
| status | output | 8 | Status code: 0x40 idle, 0x80 busy, 0x50 done, 0x41 error |
| int_reason | output | 3 | Interrupt reason code |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check the local handshake rules. The output holds still under backpressure, beats never appear without a buffered sector or while a fill is in progress, and a sector wrap always drops the buffer. They also check that mw_addr steps by one inside a request, that dma_end is a single pulse, and that busy status and irq agree with cmd_ready. Only the bench scenarios can show the byte-level results. These are that each beat carries the right byte of the right block when offsets run across request boundaries, that exactly the expected sequence of blocks is fetched, that a packet ending early leaves the request open for the next command, and that a fill error closes the request only when one is open.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

  localparam logic [7:0] ST_IDLE = 8'h40;
  localparam logic [7:0] ST_BUSY = 8'h80;
  localparam logic [7:0] ST_DONE = 8'h50;
  localparam logic [7:0] ST_FAIL = 8'h41;
  localparam logic [2:0] IRSN_COMPLETE = 3'b011;

  // offset inside a sector after moving n more bytes
  function automatic int unsigned sect_off_after(input int unsigned off,
                                                 input int unsigned n,
                                                 input int unsigned sect);
    return (off + n) % sect;
  endfunction

  // whole sectors crossed when moving n more bytes from off
  function automatic int unsigned sect_carry(input int unsigned off,
                                             input int unsigned n,
                                             input int unsigned sect);
    return (off + n) / sect;
  endfunction

endpackage

// File: rtl/ssa_sector_buf.sv
module ssa_sector_buf #(
  parameter int SECT_BYTES = 2048,
  parameter int OFF_W      = 11
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [OFF_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);

  logic [7:0] mem [SECT_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/ssa_fill_ctl.sv
module ssa_fill_ctl #(
  parameter int SECT_BYTES = 2048,
  parameter int OFF_W      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_pkt,
  input  logic             need,
  input  logic             consume_wrap,
  input  logic             fill_valid,
  input  logic             fill_err,
  output logic             fill_ready,
  output logic             sect_ok,
  output logic             fault,
  output logic             buf_we,
  output logic [OFF_W-1:0] buf_widx
);

  localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(SECT_BYTES - 1);

  logic             valid_q;
  logic [OFF_W-1:0] cnt_q;
  logic             fill_hs;

  assign fill_ready = need && !valid_q;
  assign fill_hs    = fill_valid && fill_ready;
  assign fault      = fill_hs && fill_err;
  assign buf_we     = fill_hs && !fill_err;
  assign buf_widx   = cnt_q;
  assign sect_ok    = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else if (start_pkt) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else if (fault) begin
      cnt_q   <= '0;
    end else if (fill_hs) begin
      if (cnt_q == LAST_IDX) begin
        cnt_q   <= '0;
        valid_q <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end else if (consume_wrap) begin
      valid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/ssa_stream_ctl.sv
module ssa_stream_ctl #(
  parameter int SECT_BYTES = 2048,
  parameter int OFF_W      = 11,
  parameter int LBA_W      = 32,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int PKT_W      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [LBA_W-1:0]  cmd_lba,
  input  logic [PKT_W-1:0]  cmd_bytes,
  input  logic              dreq_valid,
  input  logic [ADDR_W-1:0] dreq_addr,
  input  logic [LEN_W-1:0]  dreq_len,
  input  logic              sect_ok,
  input  logic [7:0]        rd_data,
  input  logic              mw_ready,
  input  logic              fault,
  output logic              cmd_ready,
  output logic              dreq_ready,
  output logic              mw_valid,
  output logic [ADDR_W-1:0] mw_addr,
  output logic [7:0]        mw_data,
  output logic              dma_end,
  output logic [OFF_W-1:0]  rd_idx,
  output logic [LBA_W-1:0]  cur_lba,
  output logic              need,
  output logic              start_pkt,
  output logic              wrap_evt,
  output logic              req_last,
  output logic              pkt_last
);

  logic              pkt_act_q, req_act_q, end_q;
  logic [PKT_W-1:0]  pkt_left_q;
  logic [LEN_W-1:0]  req_left_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LBA_W-1:0]  lba_q;
  logic [OFF_W-1:0]  off_q;
  logic              beat;
  logic              req_take;
  logic [OFF_W-1:0]  off_nxt;
  logic [LBA_W-1:0]  lba_step;

  assign cmd_ready  = !pkt_act_q;
  assign dreq_ready = !req_act_q;
  assign start_pkt  = cmd_valid && cmd_ready;
  assign req_take   = dreq_valid && dreq_ready;
  assign need       = pkt_act_q;
  assign mw_valid   = pkt_act_q && req_act_q && sect_ok;
  assign beat       = mw_valid && mw_ready;
  assign mw_addr    = addr_q;
  assign mw_data    = rd_data;
  assign rd_idx     = off_q;
  assign cur_lba    = lba_q;
  assign dma_end    = end_q;

  assign off_nxt  = OFF_W'(ssa_pkg::sect_off_after(32'(off_q), 32'd1, 32'(SECT_BYTES)));
  assign lba_step = LBA_W'(ssa_pkg::sect_carry(32'(off_q), 32'd1, 32'(SECT_BYTES)));
  assign wrap_evt = beat && (lba_step != '0);
  assign req_last = beat && (req_left_q == LEN_W'(1));
  assign pkt_last = beat && (pkt_left_q == PKT_W'(1));

  // packet side: block address, offset and owed bytes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_act_q  <= 1'b0;
      pkt_left_q <= '0;
      lba_q      <= '0;
      off_q      <= '0;
    end else if (fault) begin
      pkt_act_q  <= 1'b0;
      pkt_left_q <= '0;
    end else if (start_pkt) begin
      pkt_act_q  <= 1'b1;
      pkt_left_q <= cmd_bytes;
      lba_q      <= cmd_lba;
      off_q      <= '0;
    end else if (beat) begin
      pkt_left_q <= pkt_left_q - 1'b1;
      off_q      <= off_nxt;
      lba_q      <= lba_q + lba_step;
      if (pkt_last) pkt_act_q <= 1'b0;
    end
  end

  // request side: target address, remaining length, end pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_act_q  <= 1'b0;
      req_left_q <= '0;
      addr_q     <= '0;
      end_q      <= 1'b0;
    end else begin
      end_q <= 1'b0;
      if (fault && req_act_q) begin
        req_act_q <= 1'b0;
        end_q     <= 1'b1;
      end else if (req_take) begin
        req_act_q  <= 1'b1;
        req_left_q <= dreq_len;
        addr_q     <= dreq_addr;
      end else if (beat) begin
        req_left_q <= req_left_q - 1'b1;
        addr_q     <= addr_q + 1'b1;
        if (req_last) begin
          req_act_q <= 1'b0;
          end_q     <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ssa_status.sv
module ssa_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_pkt,
  input  logic       pkt_last,
  input  logic       fault,
  output logic [7:0] status,
  output logic [2:0] int_reason,
  output logic       irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status     <= ssa_pkg::ST_IDLE;
      int_reason <= '0;
      irq        <= 1'b0;
    end else if (fault) begin
      status     <= ssa_pkg::ST_FAIL;
      int_reason <= ssa_pkg::IRSN_COMPLETE;
      irq        <= 1'b1;
    end else if (start_pkt) begin
      status     <= ssa_pkg::ST_BUSY;
      int_reason <= '0;
      irq        <= 1'b0;
    end else if (pkt_last) begin
      status     <= ssa_pkg::ST_DONE;
      int_reason <= ssa_pkg::IRSN_COMPLETE;
      irq        <= 1'b1;
    end
  end

endmodule

// File: rtl/ssa_adapter.sv
module ssa_adapter #(
  parameter int SECT_BYTES = 2048,
  parameter int LBA_W      = 32,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int PKT_W      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [LBA_W-1:0]  cmd_lba,
  input  logic [PKT_W-1:0]  cmd_bytes,
  input  logic              dreq_valid,
  output logic              dreq_ready,
  input  logic [ADDR_W-1:0] dreq_addr,
  input  logic [LEN_W-1:0]  dreq_len,
  output logic              dma_end,
  output logic              fill_ready,
  output logic [LBA_W-1:0]  fill_lba,
  input  logic              fill_valid,
  input  logic [7:0]        fill_data,
  input  logic              fill_err,
  output logic              mw_valid,
  input  logic              mw_ready,
  output logic [ADDR_W-1:0] mw_addr,
  output logic [7:0]        mw_data,
  output logic [7:0]        status,
  output logic [2:0]        int_reason,
  output logic              irq
);

  localparam int OFF_W = (SECT_BYTES > 1) ? $clog2(SECT_BYTES) : 1;

  // internal events, named for the checker
  logic             sect_ok;
  logic             fault;
  logic             need;
  logic             start_pkt;
  logic             wrap_evt;
  logic             req_last;
  logic             pkt_last;
  logic             buf_we;
  logic [OFF_W-1:0] buf_widx;
  logic [OFF_W-1:0] rd_idx;
  logic [7:0]       rd_data;

  ssa_sector_buf #(.SECT_BYTES(SECT_BYTES), .OFF_W(OFF_W)) u_buf (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_idx  (buf_widx),
    .wr_data (fill_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  ssa_fill_ctl #(.SECT_BYTES(SECT_BYTES), .OFF_W(OFF_W)) u_fill (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_pkt    (start_pkt),
    .need         (need),
    .consume_wrap (wrap_evt),
    .fill_valid   (fill_valid),
    .fill_err     (fill_err),
    .fill_ready   (fill_ready),
    .sect_ok      (sect_ok),
    .fault        (fault),
    .buf_we       (buf_we),
    .buf_widx     (buf_widx)
  );

  ssa_stream_ctl #(
    .SECT_BYTES(SECT_BYTES), .OFF_W(OFF_W), .LBA_W(LBA_W),
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PKT_W(PKT_W)
  ) u_stream (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_lba    (cmd_lba),
    .cmd_bytes  (cmd_bytes),
    .dreq_valid (dreq_valid),
    .dreq_addr  (dreq_addr),
    .dreq_len   (dreq_len),
    .sect_ok    (sect_ok),
    .rd_data    (rd_data),
    .mw_ready   (mw_ready),
    .fault      (fault),
    .cmd_ready  (cmd_ready),
    .dreq_ready (dreq_ready),
    .mw_valid   (mw_valid),
    .mw_addr    (mw_addr),
    .mw_data    (mw_data),
    .dma_end    (dma_end),
    .rd_idx     (rd_idx),
    .cur_lba    (fill_lba),
    .need       (need),
    .start_pkt  (start_pkt),
    .wrap_evt   (wrap_evt),
    .req_last   (req_last),
    .pkt_last   (pkt_last)
  );

  ssa_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_pkt  (start_pkt),
    .pkt_last   (pkt_last),
    .fault      (fault),
    .status     (status),
    .int_reason (int_reason),
    .irq        (irq)
  );

endmodule

// File: rtl/ssa_adapter_chk.sv
module ssa_adapter_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic [7:0]        status,
  input logic              irq,
  input logic              dma_end,
  input logic              mw_valid,
  input logic              mw_ready,
  input logic [ADDR_W-1:0] mw_addr,
  input logic [7:0]        mw_data,
  input logic              fill_ready,
  input logic              sect_ok,
  input logic              wrap_evt,
  input logic              req_last
);

  p_busy_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> status == ssa_pkg::ST_BUSY);

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && mw_ready && !req_last) |=> mw_addr == $past(mw_addr) + ADDR_W'(1));

  p_wrap_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> !sect_ok);

  p_no_beat_unbuffered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sect_ok |-> !mw_valid);

  p_fill_excludes_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ready |-> !mw_valid);

  p_end_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_end |=> !dma_end);

  p_irq_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cmd_ready);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

endmodule

bind ssa_adapter ssa_adapter_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_ready  (cmd_ready),
  .status     (status),
  .irq        (irq),
  .dma_end    (dma_end),
  .mw_valid   (mw_valid),
  .mw_ready   (mw_ready),
  .mw_addr    (mw_addr),
  .mw_data    (mw_data),
  .fill_ready (fill_ready),
  .sect_ok    (sect_ok),
  .wrap_evt   (wrap_evt),
  .req_last   (req_last)
);

// File: tb/test_ssa_adapter.sv
module test_ssa_adapter;

  localparam int SECT = 2048;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_ready;
  logic [31:0] cmd_lba;
  logic [19:0] cmd_bytes;
  logic        dreq_valid, dreq_ready;
  logic [31:0] dreq_addr;
  logic [15:0] dreq_len;
  logic        dma_end;
  logic        fill_ready;
  logic [31:0] fill_lba;
  logic        fill_valid;
  logic [7:0]  fill_data;
  logic        fill_err;
  logic        mw_valid, mw_ready;
  logic [31:0] mw_addr;
  logic [7:0]  mw_data;
  logic [7:0]  status;
  logic [2:0]  int_reason;
  logic        irq;

  always #5 clk = ~clk;

  ssa_adapter i_ssa_adapter (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_lba(cmd_lba), .cmd_bytes(cmd_bytes),
    .dreq_valid(dreq_valid), .dreq_ready(dreq_ready), .dreq_addr(dreq_addr), .dreq_len(dreq_len),
    .dma_end(dma_end),
    .fill_ready(fill_ready), .fill_lba(fill_lba), .fill_valid(fill_valid),
    .fill_data(fill_data), .fill_err(fill_err),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
    .status(status), .int_reason(int_reason), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input longint lba, input int idx);
    return 8'((lba * 37) + (idx * 3) + (idx >> 7) + 11);
  endfunction

  // storage source and memory sink
  int          cyc  = 0;
  int          fidx = 0;
  longint      err_lba = -1;

  always @(posedge clk) begin
    if (fill_valid && fill_ready) fidx = (fill_err || fidx == SECT - 1) ? 0 : fidx + 1;
    if (!fill_ready) fidx = 0;
    cyc++;
    #1;
    fill_valid = fill_ready && (cyc % 4 != 1);
    fill_data  = pat(longint'(fill_lba), fidx);
    fill_err   = fill_valid && (longint'(fill_lba) == err_lba) && (fidx == 5);
    mw_ready   = (cyc % 3 != 0);
  end

  // behavioural reference, compared every clock
  bit          m_pkt, m_req, m_end, m_irq;
  longint      m_lba, m_addr;
  int          m_off, m_pleft, m_rleft;
  logic [7:0]  m_status;
  logic [2:0]  m_ir;
  int          n_ends = 0;
  longint      fills[$];
  bit          prev_fr, prev_stall;
  logic [31:0] prev_addr;
  logic [7:0]  prev_data;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_pkt = 0; m_req = 0; m_end = 0; m_irq = 0; m_lba = 0; m_addr = 0;
      m_off = 0; m_pleft = 0; m_rleft = 0; m_status = 8'h40; m_ir = 3'b000;
      prev_fr = 0; prev_stall = 0;
    end else begin
      bit pre_pkt, pre_req, fault, beat, n_end;
      chk("R2/R7/R9 status", status, m_status);
      chk("R7/R9 irq", irq, m_irq);
      chk("R7/R9 int_reason", int_reason, m_ir);
      chk("R6/R8/R9 dma_end", dma_end, m_end);
      chk("R2 cmd_ready", cmd_ready, !m_pkt);
      chk("R6 dreq_ready", dreq_ready, !m_req);
      if (!(m_pkt && m_req)) chk("R5/R7/R8 no beat", mw_valid, 0);
      if (fill_ready) chk("R4/R5 fill_lba", fill_lba, m_lba);
      if (fill_ready && !prev_fr) fills.push_back(longint'(fill_lba));
      if (prev_stall) begin
        chk("R10 valid held", mw_valid, 1);
        chk("R10 addr held", mw_addr, prev_addr);
        chk("R10 data held", mw_data, prev_data);
      end
      beat = mw_valid && mw_ready && m_pkt && m_req;
      if (beat) begin
        chk("R3 beat data", mw_data, pat(m_lba, m_off));
        chk("R3 beat addr", mw_addr, m_addr[31:0]);
      end
      pre_pkt = m_pkt; pre_req = m_req;
      fault = fill_valid && fill_ready && fill_err;
      n_end = 0;
      if (fault) begin
        m_pkt = 0; m_status = 8'h41; m_ir = 3'b011; m_irq = 1;
        if (m_req) begin m_req = 0; n_end = 1; end
      end else if (beat) begin
        m_off++;
        if (m_off == SECT) begin m_off = 0; m_lba++; end
        m_pleft--; m_rleft--; m_addr++;
        if (m_pleft == 0) begin m_pkt = 0; m_status = 8'h50; m_ir = 3'b011; m_irq = 1; end
        if (m_rleft == 0) begin m_req = 0; n_end = 1; end
      end
      if (cmd_valid && !pre_pkt && !fault) begin
        m_pkt = 1; m_lba = cmd_lba; m_off = 0; m_pleft = int'(cmd_bytes);
        m_status = 8'h80; m_ir = 3'b000; m_irq = 0;
      end
      if (dreq_valid && !pre_req) begin
        m_req = 1; m_rleft = int'(dreq_len); m_addr = dreq_addr;
      end
      m_end = n_end;
      if (dma_end) n_ends++;
      prev_fr = fill_ready;
      prev_stall = mw_valid && !mw_ready;
      prev_addr = mw_addr; prev_data = mw_data;
    end
  end

  task automatic send_cmd(input longint lba, input int bytes);
    @(posedge clk); #1;
    while (!cmd_ready) begin @(posedge clk); #1; end
    cmd_valid = 1; cmd_lba = 32'(lba); cmd_bytes = 20'(bytes);
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic send_req(input longint addr, input int len);
    @(posedge clk); #1;
    while (!dreq_ready) begin @(posedge clk); #1; end
    dreq_valid = 1; dreq_addr = 32'(addr); dreq_len = 16'(len);
    @(posedge clk); #1;
    dreq_valid = 0;
  endtask

  task automatic wait_ends(input int target, input string tag);
    int t = 0;
    while (n_ends < target && t < 30000) begin @(negedge clk); t++; end
    chk(tag, n_ends, target);
  endtask

  task automatic wait_irq(input string tag);
    int t = 0;
    while (!irq && t < 30000) begin @(negedge clk); t++; end
    chk(tag, irq, 1);
  endtask

  task automatic chk_fills(input string tag, input longint exp[$]);
    chk({tag, " fill count"}, fills.size(), exp.size());
    foreach (exp[i]) if (i < fills.size()) chk({tag, " fill lba"}, fills[i], exp[i]);
    fills.delete();
  endtask

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_lba = 0; cmd_bytes = 0;
    dreq_valid = 0; dreq_addr = 0; dreq_len = 0;
    fill_valid = 0; fill_data = 0; fill_err = 0; mw_ready = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 status", status, 8'h40);
    chk("R1 irq", irq, 0);
    chk("R1 int_reason", int_reason, 0);
    chk("R1 cmd_ready", cmd_ready, 1);
    chk("R1 dreq_ready", dreq_ready, 1);
    chk("R1 mw_valid", mw_valid, 0);
    chk("R1 fill_ready", fill_ready, 0);
    fills.delete();

    // six 512-byte requests across one and a half sectors
    send_cmd(5, 3072);
    for (int i = 0; i < 6; i++) begin
      send_req(32'h1000 + i * 512, 512);
      wait_ends(i + 1, "R6 quarter-sector request end");
    end
    @(negedge clk);
    chk("R7 done status", status, 8'h50);
    chk("R7 irq", irq, 1);
    chk_fills("R4 offset kept across requests", '{5, 6});

    // packet shorter than request: request stays open
    send_cmd(20, 700);
    send_req(32'h8000, 1000);
    wait_irq("R7 packet end irq");
    repeat (20) @(negedge clk);
    chk("R8 no end while request open", n_ends, 6);
    chk("R8 request still open", dreq_ready, 0);
    send_cmd(40, 300);
    wait_ends(7, "R8 request resumes and ends");
    @(negedge clk);
    chk("R8 second packet done", status, 8'h50);
    chk_fills("R8 fetch order", '{20, 40});

    // odd lengths across a sector boundary
    send_cmd(100, 2051);
    send_req(32'h2_0000, 1);
    wait_ends(8, "R6 single byte");
    send_req(32'h3_0000, 2047);
    wait_ends(9, "R6 rest of sector");
    send_req(32'h4_0000, 3);
    wait_ends(10, "R4 bytes past wrap");
    chk_fills("R4 wrap refetch", '{100, 101});

    // storage error with an open request
    err_lba = 77;
    send_cmd(77, 64);
    send_req(32'h500, 64);
    wait_ends(11, "R9 end on fault");
    @(negedge clk);
    chk("R9 error status", status, 8'h41);
    chk("R9 irq", irq, 1);
    chk("R9 int_reason", int_reason, 3'b011);

    // storage error without a request
    send_cmd(77, 10);
    wait_irq("R9 irq without request");
    repeat (10) @(negedge clk);
    chk("R9 no end without request", n_ends, 11);
    chk("R9 status", status, 8'h41);

    // recovery
    err_lba = -1;
    send_cmd(78, 16);
    send_req(32'h600, 16);
    wait_ends(12, "R2 recovery request");
    @(negedge clk);
    chk("R2 recovery status", status, 8'h50);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R6 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule